// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block takes one decoded compressed push or pop operation and turns it into a series of single-word memory accesses. A final stack-pointer update follows the accesses. A start pulse carries four things: the operation, a 4-bit register-list code, a 2-bit immediate that scales the frame, and a mode bit for the reduced (16-register) base set. The stack pointer is sampled in the same cycle as the start pulse.

Each access step presents a register number, a word address and a store/load direction, and waits for a memory-ready handshake. After the last access the block signals a few things to the register file: an optional clear of the return-value register (a0, x10), a stack-pointer write-back, and then a one-cycle completion pulse. For the two returning variants, that pulse comes with a request to jump to the restored link register. The register file and memory are outside the block.

Top module: `stk_frame_seq`

## Requirements
- R1: The list code selects registers in this fixed order: ra (x1), s0 (x8), s1 (x9), s2..s11 (x18..x27). Codes 4..14 take the first (code−3) entries. Code 15 takes all 13. The register of each step appears on `mem_reg_o`.
- R2: The frame adjustment is the list size in bytes (4 per register), rounded up to a multiple of 16, plus 16 × `spimm_i`.
- R3: Push (`op_i`=0) stores with `mem_we_o`=1. Step i (from 0) stores list entry n−1−i at sp−4(i+1). The stack pointer is then written with sp−adjustment.
- R4: Pop (`op_i`=1), pop-return (`op_i`=2) and pop-return-zero (`op_i`=3) load with `mem_we_o`=0. Step i loads list entry n−1−i from sp+adjustment−4(i+1). The stack pointer is then written with sp+adjustment.
- R5: The first access is presented in the cycle after an accepted start. One access completes per cycle in which `mem_ready_i` is high. Address, direction and register stay stable while ready is low.
- R6: For `op_i`=3 only, `zero_a0_o` pulses for one cycle, in the cycle after the last load completes and before the stack-pointer write.
- R7: `sp_we_o` is high for exactly one cycle. `done_o` pulses in the next cycle, and `ret_req_o` pulses with it for `op_i`=2 and 3 only.
- R8: A start with code below 4 is illegal. In reduced mode, a code above 6 is also illegal. An illegal start raises `illegal_o` for one cycle, in the cycle after the start, and performs no access and no write.
- R9: A start that arrives while `busy_o` is high is ignored. The running sequence is not changed by it.
- R10: During and right after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one operation |
| op_i | input | 2 | 0 push, 1 pop, 2 pop-return, 3 pop-return-zero |
| list_i | input | 4 | Register-list code |
| spimm_i | input | 2 | Extra frame size in 16-byte units |
| emb_mode_i | input | 1 | Reduced base register set |
| sp_i | input | XLEN | Stack pointer, sampled at start |
| mem_ready_i | input | 1 | Memory accepts the current access |
| busy_o | output | 1 | Sequence in progress |
| mem_req_o | output | 1 | Access valid |
| mem_we_o | output | 1 | 1 store, 0 load |
| mem_addr_o | output | XLEN | Word address of the access |
| mem_reg_o | output | 5 | Register number of the access |
| sp_we_o | output | 1 | Stack-pointer write strobe |
| sp_wdata_o | output | XLEN | New stack-pointer value |
| zero_a0_o | output | 1 | Clear a0 strobe |
| ret_req_o | output | 1 | Jump to restored ra |
| done_o | output | 1 | Sequence complete pulse |
| illegal_o | output | 1 | Start rejected |

## Verification
Every result has a fixed latency. The first access appears one cycle after the start. Each further access follows one cycle after a ready-high cycle. The a0 clear, the stack-pointer write and the done/return pulses follow the last completed access at offsets of one, one or two, and two or three cycles. A rejected start shows its flag exactly one cycle later. The bench drives and samples on the falling edge. It walks a behavioural model through the same cycles, one step per cycle, and compares every output against it, including the cycles in which ready is held low. Stall patterns vary the distance between accesses, and the model never assumes a fixed total length.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  typedef enum logic [1:0] {
    OP_PUSH    = 2'd0,
    OP_POP     = 2'd1,
    OP_POPRET  = 2'd2,
    OP_POPRETZ = 2'd3
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_CLRA0,
    ST_SPWB,
    ST_FIN
  } stk_state_e;

  localparam int unsigned MAX_REGS     = 13;
  localparam int unsigned LIST_MIN     = 4;
  localparam int unsigned EMB_LIST_MAX = 6;
  localparam int unsigned FULL_CODE    = 15;

  // number of registers named by a legal list code
  function automatic int unsigned list_len(input logic [3:0] code);
    if (code < 4'(LIST_MIN)) return 0;
    if (code == 4'(FULL_CODE)) return MAX_REGS;
    return int'(code) - 3;
  endfunction

  // architectural register number of list position k
  function automatic logic [4:0] list_reg_num(input int unsigned k);
    case (k)
      0:       return 5'd1;
      1:       return 5'd8;
      2:       return 5'd9;
      default: return 5'(k + 15);
    endcase
  endfunction

  function automatic logic list_illegal(input logic [3:0] code, input logic emb);
    return (code < 4'(LIST_MIN)) || (emb && (code > 4'(EMB_LIST_MAX)));
  endfunction

endpackage

// File: rtl/stk_list_map.sv
module stk_list_map
  import stk_seq_pkg::*;
#(
  parameter int unsigned NREGS = MAX_REGS,
  parameter int unsigned REGW  = 5,
  parameter int unsigned IDXW  = $clog2(NREGS + 1)
) (
  input  logic [3:0]      code_i,
  input  logic [IDXW-1:0] step_i,
  output logic [IDXW-1:0] len_o,
  output logic [REGW-1:0] reg_o
);

  logic [REGW-1:0] order_tbl [NREGS];
  logic [IDXW-1:0] pos_w;

  for (genvar k = 0; k < NREGS; k++) begin : g_order
    assign order_tbl[k] = REGW'(list_reg_num(k));
  end

  assign len_o = IDXW'(list_len(code_i));

  // steps walk the list from its last entry back to ra
  assign pos_w = len_o - IDXW'(1) - step_i;

  always_comb begin
    reg_o = '0;
    for (int k = 0; k < NREGS; k++) begin
      if (pos_w == IDXW'(k)) reg_o = order_tbl[k];
    end
  end

endmodule

// File: rtl/stk_frame_calc.sv
module stk_frame_calc #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDXW = 4
) (
  input  logic            is_push_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [IDXW-1:0] len_i,
  input  logic [1:0]      spimm_i,
  input  logic [IDXW-1:0] step_i,
  output logic [XLEN-1:0] adj_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] sp_next_o
);

  localparam int unsigned WORD_BYTES = XLEN / 8;
  localparam int unsigned ALIGN      = 16;

  function automatic logic [XLEN-1:0] frame_adj(input logic [IDXW-1:0] n,
                                                input logic [1:0] imm);
    logic [XLEN-1:0] bytes, base;
    bytes = XLEN'(n) * XLEN'(WORD_BYTES);
    base  = (bytes + XLEN'(ALIGN - 1)) & ~XLEN'(ALIGN - 1);
    return base + XLEN'(imm) * XLEN'(ALIGN);
  endfunction

  function automatic logic [XLEN-1:0] slot_addr(input logic [XLEN-1:0] top,
                                                input logic [IDXW-1:0] step);
    return top - (XLEN'(step) + XLEN'(1)) * XLEN'(WORD_BYTES);
  endfunction

  logic [XLEN-1:0] top_w;

  assign adj_o     = frame_adj(len_i, spimm_i);
  assign top_w     = is_push_i ? sp_i : sp_i + adj_o;
  assign addr_o    = slot_addr(top_w, step_i);
  assign sp_next_o = is_push_i ? sp_i - adj_o : sp_i + adj_o;

endmodule

// File: rtl/stk_frame_seq.sv
module stk_frame_seq
  import stk_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [3:0]      list_i,
  input  logic [1:0]      spimm_i,
  input  logic            emb_mode_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic            mem_ready_i,
  output logic            busy_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [4:0]      mem_reg_o,
  output logic            sp_we_o,
  output logic [XLEN-1:0] sp_wdata_o,
  output logic            zero_a0_o,
  output logic            ret_req_o,
  output logic            done_o,
  output logic            illegal_o
);

  localparam int unsigned IDXW = $clog2(MAX_REGS + 1);
  localparam int unsigned REGW = 5;

  stk_state_e      state_q;
  stk_op_e         op_q;
  logic [3:0]      code_q;
  logic [1:0]      spimm_q;
  logic [XLEN-1:0] sp_q;
  logic [IDXW-1:0] step_q;
  logic            illegal_q;

  // named internal events
  logic            start_seen, start_bad, start_take;
  logic            xfer_fire, last_fire;
  logic [IDXW-1:0] len_w;
  logic [REGW-1:0] reg_w;
  logic [XLEN-1:0] adj_w, addr_w, sp_next_w;
  logic            is_push;

  assign is_push    = (op_q == OP_PUSH);
  assign start_seen = start_i && (state_q == ST_IDLE);
  assign start_bad  = start_seen && list_illegal(list_i, emb_mode_i);
  assign start_take = start_seen && !start_bad;
  assign xfer_fire  = (state_q == ST_XFER) && mem_ready_i;
  assign last_fire  = xfer_fire && (step_q == len_w - IDXW'(1));

  stk_list_map #(
    .NREGS (MAX_REGS),
    .REGW  (REGW),
    .IDXW  (IDXW)
  ) u_list_map (
    .code_i (code_q),
    .step_i (step_q),
    .len_o  (len_w),
    .reg_o  (reg_w)
  );

  stk_frame_calc #(
    .XLEN (XLEN),
    .IDXW (IDXW)
  ) u_frame_calc (
    .is_push_i (is_push),
    .sp_i      (sp_q),
    .len_i     (len_w),
    .spimm_i   (spimm_q),
    .step_i    (step_q),
    .adj_o     (adj_w),
    .addr_o    (addr_w),
    .sp_next_o (sp_next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_PUSH;
      code_q    <= 4'(LIST_MIN);
      spimm_q   <= '0;
      sp_q      <= '0;
      step_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= start_bad;
      unique case (state_q)
        ST_IDLE: begin
          if (start_take) begin
            op_q    <= stk_op_e'(op_i);
            code_q  <= list_i;
            spimm_q <= spimm_i;
            sp_q    <= sp_i;
            step_q  <= '0;
            state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (last_fire) begin
            state_q <= (op_q == OP_POPRETZ) ? ST_CLRA0 : ST_SPWB;
          end else if (xfer_fire) begin
            step_q <= step_q + IDXW'(1);
          end
        end
        ST_CLRA0: state_q <= ST_SPWB;
        ST_SPWB:  state_q <= ST_FIN;
        ST_FIN:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign mem_req_o  = (state_q == ST_XFER);
  assign mem_we_o   = mem_req_o && is_push;
  assign mem_addr_o = mem_req_o ? addr_w : '0;
  assign mem_reg_o  = mem_req_o ? reg_w : '0;
  assign zero_a0_o  = (state_q == ST_CLRA0);
  assign sp_we_o    = (state_q == ST_SPWB);
  assign sp_wdata_o = sp_we_o ? sp_next_w : '0;
  assign done_o     = (state_q == ST_FIN);
  assign ret_req_o  = done_o && ((op_q == OP_POPRET) || (op_q == OP_POPRETZ));
  assign illegal_o  = illegal_q;

  // stalled access must not move
  assert_hold_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_reg_o));

  assert_clear_then_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_a0_o |=> sp_we_o);

  assert_done_after_sp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(sp_we_o));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !busy_o && !mem_req_o && !sp_we_o);

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_o, zero_a0_o, sp_we_o, done_o}));

  assert_busy_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i && start_i |=> mem_req_o);

endmodule

// File: tb/stk_frame_seq_bench.sv
`timescale 1ns/1ps
module stk_frame_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic [3:0]  list_i;
  logic [1:0]  spimm_i;
  logic        emb_mode_i;
  logic [31:0] sp_i;
  logic        mem_ready_i;
  logic        busy_o, mem_req_o, mem_we_o, sp_we_o, zero_a0_o, ret_req_o, done_o, illegal_o;
  logic [31:0] mem_addr_o, sp_wdata_o;
  logic [4:0]  mem_reg_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stk_frame_seq u_stk_frame_seq (
    .clk, .rst_n, .start_i, .op_i, .list_i, .spimm_i, .emb_mode_i, .sp_i,
    .mem_ready_i, .busy_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_reg_o,
    .sp_we_o, .sp_wdata_o, .zero_a0_o, .ret_req_o, .done_o, .illegal_o
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // reference register list, written from the requirement text
  function automatic int ref_len(input int code);
    if (code == 15) return 13;
    return code - 3;
  endfunction

  function automatic int ref_reg(input int pos);
    int names[$] = '{1, 8, 9};
    for (int s = 2; s <= 11; s++) names.push_back(16 + s);
    return names[pos];
  endfunction

  function automatic int ref_adj(input int code, input int imm);
    int bytes = ref_len(code) * 4;
    int frame = ((bytes + 15) / 16) * 16;
    return frame + imm * 16;
  endfunction

  task automatic idle_quiet(input string rq);
    check(rq, "busy", busy_o, 0);
    check(rq, "mem_req", mem_req_o, 0);
    check(rq, "sp_we", sp_we_o, 0);
    check(rq, "done", done_o, 0);
    check(rq, "ret_req", ret_req_o, 0);
    check(rq, "zero_a0", zero_a0_o, 0);
  endtask

  task automatic run_op(input int op, input int code, input int imm,
                        input logic [31:0] sp, input bit emb,
                        input int stall_every, input bit poke);
    int n, adj, cyc;
    logic [31:0] top, sp_exp;
    int regq[$];
    @(negedge clk);
    start_i = 1; op_i = 2'(op); list_i = 4'(code); spimm_i = 2'(imm);
    emb_mode_i = emb; sp_i = sp;
    @(negedge clk);
    start_i = 0; sp_i = 32'hDEAD_0000;
    n = ref_len(code);
    adj = ref_adj(code, imm);
    for (int k = n - 1; k >= 0; k--) regq.push_back(ref_reg(k));
    top = (op == 0) ? sp : sp + adj;
    sp_exp = (op == 0) ? sp - adj : sp + adj;
    cyc = 0;
    for (int i = 0; i < n; i++) begin
      bit taken = 0;
      while (!taken) begin
        bit rdy;
        check("R5", "mem_req", mem_req_o, 1);
        check(op == 0 ? "R3" : "R4", "direction", mem_we_o, (op == 0) ? 1 : 0);
        check(op == 0 ? "R3" : "R4", "address", mem_addr_o, top - 4 * (i + 1));
        check("R1", "register", mem_reg_o, regq[i]);
        rdy = (stall_every == 0) || ((cyc % stall_every) != 0);
        mem_ready_i = rdy;
        if (poke && i == 1) begin
          // R9: competing start while busy
          start_i = 1; op_i = 2'd0; list_i = 4'd15; spimm_i = 2'd3; sp_i = 32'h0;
        end
        @(negedge clk);
        start_i = 0;
        cyc++;
        taken = rdy;
      end
    end
    mem_ready_i = 0;
    check("R5", "mem_req after list", mem_req_o, 0);
    if (op == 3) begin
      check("R6", "zero_a0", zero_a0_o, 1);
      check("R6", "sp_we early", sp_we_o, 0);
      @(negedge clk);
    end
    check("R6", "zero_a0 absent", zero_a0_o, 0);
    check("R7", "sp_we", sp_we_o, 1);
    check("R2", "sp_wdata", sp_wdata_o, sp_exp);
    check("R7", "done early", done_o, 0);
    @(negedge clk);
    check("R7", "done", done_o, 1);
    check("R7", "ret_req", ret_req_o, (op >= 2) ? 1 : 0);
    check("R7", "sp_we single", sp_we_o, 0);
    @(negedge clk);
    idle_quiet("R9");
  endtask

  task automatic run_bad(input int code, input bit emb);
    @(negedge clk);
    start_i = 1; op_i = 2'd1; list_i = 4'(code); spimm_i = 2'd1;
    emb_mode_i = emb; sp_i = 32'h0000_4000;
    @(negedge clk);
    start_i = 0;
    check("R8", "illegal", illegal_o, 1);
    idle_quiet("R8");
    @(negedge clk);
    check("R8", "illegal single", illegal_o, 0);
    idle_quiet("R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; op_i = 0; list_i = 4; spimm_i = 0;
    emb_mode_i = 0; sp_i = 0; mem_ready_i = 0;
    repeat (3) @(negedge clk);
    idle_quiet("R10");
    check("R10", "illegal", illegal_o, 0);
    rst_n = 1;
    @(negedge clk);
    idle_quiet("R10");
    check("R10", "illegal", illegal_o, 0);

    run_op(0, 4, 0, 32'h0000_1000, 0, 0, 0);
    run_op(0, 15, 3, 32'h0000_2000, 0, 3, 0);
    run_op(1, 5, 1, 32'h0000_1F00, 0, 0, 0);
    run_op(2, 8, 2, 32'h0000_3000, 0, 0, 0);
    run_op(3, 14, 0, 32'h0000_3800, 0, 2, 1);
    run_op(1, 7, 0, 32'h0000_0800, 0, 0, 0);
    run_op(2, 6, 1, 32'h0000_0400, 1, 4, 0);
    run_op(0, 12, 1, 32'h0000_5000, 0, 4, 1);
    run_op(3, 4, 3, 32'h0000_6000, 1, 0, 0);

    run_bad(3, 0);
    run_bad(0, 1);
    run_bad(7, 1);
    run_bad(15, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule